// File: doc/BRIEF.md
# Overcurrent Deglitch and Retry Sequencer

This block protects a bank of switch channels, four by default. Each channel has a current-limit flag. The flag must stay raised for a run of consecutive clock samples before the channel is shut off. This filters out short spikes. Once a channel is shut off, it stays off for a fixed retry window. It then rearms without any help from outside. Each channel has its own state machine and its own counter, so the channels do not affect one another.

Three inputs act on every channel at once:
- A synchronous reset clears every pending or held fault on the next edge.
- A thermal flag forces every channel off while it is high and sets the fault indication. The channel sequencers keep running underneath it.
- A supply-undervoltage flag forces every channel off and holds all internal state cleared for as long as it stays high. Operation restarts from a clean state once the flag drops.

The active-low fault output is registered, so it cannot glitch. Both intervals are parameters counted in clock cycles.

Top module: `ocp_retry_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released with all flags low, `ch_off` is all zeros and `fault_n` is 1.
- R2: A current-limit pulse on a channel shorter than DEGLITCH_CYCLES consecutive rising-edge samples never raises that channel's `ch_off` bit. A low sample restarts the count from zero.
- R3: When `ilim[i]` is sampled high on DEGLITCH_CYCLES consecutive edges, `ch_off[i]` rises right after the last of those edges.
- R4: A channel stays off for exactly RETRY_CYCLES cycles and then clears by itself. `ilim[i]` has no effect during that window. If the flag is still high after the window, a fresh deglitch count starts on the following edge.
- R5: `fault_n` is registered. It is 0 in the cycle after any cycle in which a channel holds a fault or `therm` is high. Otherwise it is 1.
- R6: `rst` high at an edge clears every channel's fault and deglitch progress at that edge. It does not wait for the retry window.
- R7: While `therm` is high, every bit of `ch_off` is 1 in the same cycle. The channel sequencers keep counting underneath. Once `therm` drops, each channel returns to its own fault state.
- R8: While `uv` is high, every bit of `ch_off` is 1, `fault_n` is 1 after the next edge, and all channel state is cleared at each edge.
- R9: Each channel's sequencer runs independently. A fault or glitch on one channel does not change any other channel's `ch_off` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all faults at once |
| uv | input | 1 | Supply undervoltage flag; holds all state cleared and forces channels off |
| therm | input | 1 | Over-temperature flag; forces all channels off while high |
| ilim | input | NUM_CH | Per-channel current-limit-active flags |
| ch_off | output | NUM_CH | Per-channel disable; 1 turns the channel's switch off |
| fault_n | output | 1 | Registered active-low fault indication (open-drain pull-down request) |

## Verification
The bench builds the block with DEGLITCH_CYCLES = 4 and RETRY_CYCLES = 10. With these small values, every pulse length from one sample up to one past the threshold can be swept on every channel. So can pulses that outlast the whole retry window, which tests rearming while the flag is still high. The short windows also make it cheap to place reset, thermal and undervoltage events at chosen points inside a deglitch run or a hold. Each such case is compared cycle by cycle against a counter model kept in the bench.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    CH_IDLE     = 2'd0,
    CH_DEGLITCH = 2'd1,
    CH_HOLD     = 2'd2
  } ch_state_t;

  // Counter width large enough to hold the longer of the two windows.
  function automatic int cnt_bits(input int dg, input int rt);
    int mx;
    mx = (dg > rt) ? dg : rt;
    return (mx < 2) ? 1 : $clog2(mx);
  endfunction

endpackage

// File: rtl/ocp_chan.sv
module ocp_chan
  import ocp_pkg::*;
#(
  parameter int DEGLITCH_CYCLES = 175,
  parameter int RETRY_CYCLES    = 60000
) (
  input  logic clk,
  input  logic clr,
  input  logic ilim,
  output logic faulted
);

  localparam int CW = cnt_bits(DEGLITCH_CYCLES, RETRY_CYCLES);
  localparam logic [CW-1:0] DG_LAST = CW'(DEGLITCH_CYCLES - 1);
  localparam logic [CW-1:0] RT_LAST = CW'(RETRY_CYCLES - 1);

  ch_state_t     state_q;
  logic [CW-1:0] cnt_q;

  // Named internal events.
  logic dg_done;
  logic dg_abort;
  logic hold_done;

  assign dg_done   = (state_q == CH_DEGLITCH) && ilim && (cnt_q == DG_LAST);
  assign dg_abort  = (state_q == CH_DEGLITCH) && !ilim;
  assign hold_done = (state_q == CH_HOLD) && (cnt_q == RT_LAST);

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        CH_IDLE: begin
          if (ilim) begin
            state_q <= CH_DEGLITCH;
            cnt_q   <= CW'(1);
          end
        end
        CH_DEGLITCH: begin
          if (dg_abort) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
          end else if (dg_done) begin
            state_q <= CH_HOLD;
            cnt_q   <= '0;
          end else begin
            cnt_q   <= cnt_q + CW'(1);
          end
        end
        CH_HOLD: begin
          if (hold_done) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q   <= cnt_q + CW'(1);
          end
        end
        default: begin
          state_q <= CH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign faulted = (state_q == CH_HOLD);

  // R2
  dg_abort_chk: assert property (@(posedge clk) disable iff (clr)
    dg_abort |=> (state_q == CH_IDLE) && (cnt_q == '0));

  // R3
  dg_enter_hold_chk: assert property (@(posedge clk) disable iff (clr)
    dg_done |=> faulted);

  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (clr)
    (faulted && !hold_done) |=> faulted);

  // R4
  hold_release_chk: assert property (@(posedge clk) disable iff (clr)
    hold_done |=> !faulted);

endmodule

// File: rtl/ocp_fault_out.sv
module ocp_fault_out #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic [NUM_CH-1:0] ch_fault,
  input  logic              therm,
  output logic              fault_n
);

  logic any_fault;
  assign any_fault = (|ch_fault) || therm;

  always_ff @(posedge clk) begin
    if (clr) fault_n <= 1'b1;
    else     fault_n <= ~any_fault;
  end

  // R5
  fault_low_chk: assert property (@(posedge clk) disable iff (clr)
    any_fault |=> !fault_n);

  // R5
  fault_high_chk: assert property (@(posedge clk) disable iff (clr)
    !any_fault |=> fault_n);

endmodule

// File: rtl/ocp_retry_seq.sv
module ocp_retry_seq #(
  parameter int NUM_CH          = 4,
  parameter int DEGLITCH_CYCLES = 175,
  parameter int RETRY_CYCLES    = 60000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uv,
  input  logic              therm,
  input  logic [NUM_CH-1:0] ilim,
  output logic [NUM_CH-1:0] ch_off,
  output logic              fault_n
);

  logic              logic_clr;
  logic [NUM_CH-1:0] ch_fault;

  assign logic_clr = rst || uv;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ocp_chan #(
      .DEGLITCH_CYCLES(DEGLITCH_CYCLES),
      .RETRY_CYCLES   (RETRY_CYCLES)
    ) u_chan (
      .clk    (clk),
      .clr    (logic_clr),
      .ilim   (ilim[g]),
      .faulted(ch_fault[g])
    );
  end

  assign ch_off = ch_fault | {NUM_CH{therm}} | {NUM_CH{uv}};

  ocp_fault_out #(.NUM_CH(NUM_CH)) u_fault (
    .clk     (clk),
    .clr     (logic_clr),
    .ch_fault(ch_fault),
    .therm   (therm),
    .fault_n (fault_n)
  );

  // R7
  therm_all_off_chk: assert property (@(posedge clk) therm |-> (&ch_off));

  // R8
  uv_all_off_chk: assert property (@(posedge clk) uv |-> (&ch_off));

  // R6
  rst_clears_chk: assert property (@(posedge clk) (rst && !uv && !therm) |=> (ch_off == '0) || therm || uv);

  // R8
  uv_fault_idle_chk: assert property (@(posedge clk) uv |=> fault_n);

endmodule

// File: tb/ocp_retry_seq_tb.sv
`timescale 1ns/1ps
module ocp_retry_seq_tb;

  localparam int NCH = 4;
  localparam int DG  = 4;
  localparam int RT  = 10;

  logic           clk = 1'b0;
  logic           rst, uv, therm;
  logic [NCH-1:0] ilim;
  logic [NCH-1:0] ch_off;
  logic           fault_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int run  [NCH];
  int hold [NCH];
  bit exp_fn;

  always #2.5 clk = ~clk;

  ocp_retry_seq #(.NUM_CH(NCH), .DEGLITCH_CYCLES(DG), .RETRY_CYCLES(RT)) u_dut (
    .clk(clk), .rst(rst), .uv(uv), .therm(therm), .ilim(ilim),
    .ch_off(ch_off), .fault_n(fault_n)
  );

  // One clock: drive at negedge, update model at the edge, compare after it.
  task automatic step(input logic [NCH-1:0] il, input logic th, input logic rs,
                      input logic u, input string tag);
    bit any;
    logic [NCH-1:0] exp_off;
    @(negedge clk);
    ilim = il; therm = th; rst = rs; uv = u;
    @(posedge clk);
    #1;
    any = th;
    for (int i = 0; i < NCH; i++) if (hold[i] > 0) any = 1;
    exp_fn = (rs || u) ? 1'b1 : !any;
    for (int i = 0; i < NCH; i++) begin
      if (rs || u) begin
        run[i] = 0; hold[i] = 0;
      end else if (hold[i] > 0) begin
        hold[i] = hold[i] - 1; run[i] = 0;
      end else if (il[i]) begin
        run[i] = run[i] + 1;
        if (run[i] == DG) begin hold[i] = RT; run[i] = 0; end
      end else begin
        run[i] = 0;
      end
    end
    for (int i = 0; i < NCH; i++) exp_off[i] = (hold[i] > 0) || th || u;
    checks++;
    if (ch_off !== exp_off) begin
      errors++;
      $display("FAIL %s ch_off actual %b expected %b at %0t", tag, ch_off, exp_off, $time);
    end
    checks++;
    if (fault_n !== exp_fn) begin
      errors++;
      $display("FAIL R5 (%s) fault_n actual %b expected %b at %0t", tag, fault_n, exp_fn, $time);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step('0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin run[i] = 0; hold[i] = 0; end
    ilim = '0; therm = 0; uv = 0; rst = 1;
    // R1: reset state
    step('0, 0, 1, 0, "R1");
    step('0, 0, 1, 0, "R1");
    step('0, 0, 0, 0, "R1");

    // R2 / R3 / R4: pulse-length sweep on every channel
    for (int ch = 0; ch < NCH; ch++) begin
      for (int len = 1; len <= DG + RT + 2; len++) begin
        if (len > DG + 1 && len < DG + RT + 2) continue;
        for (int k = 0; k < len; k++)
          step(NCH'(1) << ch, 0, 0, 0, (len < DG) ? "R2" : ((k < DG) ? "R3" : "R4"));
        idle(RT + 3, (len < DG) ? "R2" : "R4");
      end
    end

    // R2: glitch train with gaps, count must restart
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < DG - 1; j++) step(4'b0001, 0, 0, 0, "R2");
      step('0, 0, 0, 0, "R2");
    end

    // R9: channel 0 held high while channel 2 glitches
    for (int k = 0; k < DG + RT + 4; k++)
      step({1'b0, (k % 3) != 2, 1'b0, 1'b1}, 0, 0, 0, "R9");
    idle(RT + 3, "R9");

    // R6: reset in mid-hold and mid-deglitch
    for (int k = 0; k < DG + 3; k++) step(4'b0010, 0, 0, 0, "R6");
    step(4'b0110, 0, 1, 0, "R6");
    step(4'b0000, 0, 0, 0, "R6");
    idle(3, "R6");

    // R7: thermal over a deglitch and a hold
    for (int k = 0; k < DG + 6; k++) step(4'b1000, (k >= 2 && k < 8), 0, 0, "R7");
    idle(RT + 3, "R7");
    step('0, 1, 0, 0, "R7");
    step('0, 1, 0, 0, "R7");
    idle(3, "R7");

    // R8: undervoltage during a hold, then recovery
    for (int k = 0; k < DG + 2; k++) step(4'b0101, 0, 0, 0, "R8");
    step(4'b0101, 0, 0, 1, "R8");
    step(4'b0101, 1, 0, 1, "R8");
    step(4'b0101, 0, 0, 1, "R8");
    for (int k = 0; k < DG + RT + 2; k++) step(4'b0100, 0, 0, 0, "R8");
    idle(RT + 3, "R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule